// File: doc/BRIEF.md
# Soft Mute and Fade Level Controller

This block scales a stream of signed stereo audio samples by a single volume level between 0 and 128. Each output sample equals the input sample times the level, divided by 128. A small command port sets the level. Mute, attenuate and full scale each choose a target level. Two single-step commands nudge the level up or down by one unit. Any change to a new target is made as a slow ramp of one unit per prescaled tick, so the audio never jumps and no click is heard.

The full-scale target depends on an oversampling flag. When the flag is set, full scale stops at 120 instead of 128, which leaves about half a decibel of headroom for a following interpolation filter. A `muted` flag tells the rest of the audio path when the level has reached zero.

Top module: `fade_ctrl`

## Requirements
- R1: After reset the level is 0, `muted` is high, `out_valid` is low and both outputs are zero.
- R2: `out_valid` rises one clock after `smp_valid`. Each output is floor(sample × level / 128), and both channels use the same level.
- R3: Full scale (command bits [2:0] = 001) sets the target to `FULL_LVL` (128) when `os_en` is low, and to `FULL_OS_LVL` (120) when `os_en` is high. The level never exceeds `FULL_LVL`.
- R4: Attenuate (bits [2:0] = 010 or 011) sets the target to `ATTEN_LVL` (32).
- R5: Mute (bits [2:0] = 000) sets the target to 0. `muted` is high exactly when the level is 0, and a sample taken while muted comes out as zero.
- R6: While the level differs from the target, it moves one unit toward the target on each tick. Ticks occur once every `TICK_DIV` clocks, so in any `4·M` clocks after a target-setting command (with `TICK_DIV` = 4) the level moves exactly `M` units. The level never changes by more than one unit per clock.
- R7: Step up (bits [2:0] = 101) and step down (100) change the level by exactly one unit on the clock edge that takes the command. They also make that new level the target, so no ramp follows.
- R8: A step up when the level is already at the current full-scale ceiling has no effect. A step down when the level is 0 has no effect.
- R9: A command taken during a ramp replaces the target at once, and the ramp turns toward the new target.
- R10: Command bit 3 is ignored. The codes 110 and 111 leave both level and target unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, one clock per command |
| cmd_code | input | 4 | Command code; bits [2:0] select the operation |
| os_en | input | 1 | Oversampling enabled; lowers the full-scale target |
| smp_valid | input | 1 | Input sample pair valid |
| smp_l | input | 16 | Left input sample, two's complement |
| smp_r | input | 16 | Right input sample, two's complement |
| out_valid | output | 1 | Scaled sample pair valid |
| out_l | output | 16 | Scaled left sample |
| out_r | output | 16 | Scaled right sample |
| muted | output | 1 | High while the level is 0 |

## Verification
The bench builds the block with `TICK_DIV` = 4. A full 0-to-128 ramp then lasts 512 clocks instead of about 3 ms, so complete ramps, ramp reversals and exact tick counts all fit in a short run. The bench reads the level through the normal sample path: it feeds 16384 on both channels and divides the output by 128. This lets it follow the level unit by unit across every ramp and step command. Both ceilings are reached by switching `os_en`, and the step and saturation checks are made at 0, 120 and 128.

// File: rtl/fade_pkg.sv
package fade_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_MUTE,
        OP_ATTEN,
        OP_FULL,
        OP_DOWN,
        OP_UP
    } fade_op_e;

    // Bit 3 of the code is a don't-care; 11x has no operation.
    function automatic fade_op_e decode_cmd(input logic [3:0] code);
        fade_op_e op;
        casez (code)
            4'b?000: op = OP_MUTE;
            4'b?001: op = OP_FULL;
            4'b?01?: op = OP_ATTEN;
            4'b?100: op = OP_DOWN;
            4'b?101: op = OP_UP;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/fade_tick.sv
module fade_tick #(
    parameter int DIV = 1150
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == CW'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == CW'(DIV - 1));

    // R6: ticks are isolated pulses when the divider exceeds one
    p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/fade_level.sv
module fade_level
    import fade_pkg::*;
#(
    parameter int FULL_LVL    = 128,
    parameter int FULL_OS_LVL = 120,
    parameter int ATTEN_LVL   = 32,
    parameter int LW          = $clog2(FULL_LVL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_code,
    input  logic          os_en,
    output logic [LW-1:0] lvl
);
    fade_op_e      op;
    logic [LW-1:0] tgt;
    logic [LW-1:0] ceil_lvl;

    assign op       = decode_cmd(cmd_code);
    assign ceil_lvl = os_en ? LW'(FULL_OS_LVL) : LW'(FULL_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= '0;
            tgt <= '0;
        end else if (cmd_valid && op != OP_NONE) begin
            unique case (op)
                OP_MUTE:  tgt <= '0;
                OP_ATTEN: tgt <= LW'(ATTEN_LVL);
                OP_FULL:  tgt <= ceil_lvl;
                OP_DOWN: begin
                    if (lvl != '0) begin
                        lvl <= lvl - LW'(1);
                        tgt <= lvl - LW'(1);
                    end else begin
                        tgt <= lvl;
                    end
                end
                OP_UP: begin
                    if (lvl < ceil_lvl) begin
                        lvl <= lvl + LW'(1);
                        tgt <= lvl + LW'(1);
                    end else begin
                        tgt <= lvl;
                    end
                end
                default: tgt <= tgt;
            endcase
        end else if (tick) begin
            if (lvl < tgt)
                lvl <= lvl + LW'(1);
            else if (lvl > tgt)
                lvl <= lvl - LW'(1);
        end
    end

    // R3: the level stays within the full-scale range
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        lvl <= LW'(FULL_LVL));

    // R6: at most one unit of movement per clock
    p_step_by_one_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lvl == $past(lvl) || lvl == $past(lvl) + LW'(1)
                  || lvl == $past(lvl) - LW'(1)));

    // R8: step up at the ceiling leaves the level alone
    p_ceiling_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_UP && lvl >= ceil_lvl) |=> $stable(lvl));

    // R8: step down at zero leaves the level at zero
    p_floor_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == OP_DOWN && lvl == '0) |=> lvl == '0);

endmodule

// File: rtl/fade_scale.sv
module fade_scale #(
    parameter int SW    = 16,
    parameter int LW    = 8,
    parameter int SHIFT = 7
) (
    input  logic signed [SW-1:0] smp,
    input  logic        [LW-1:0] lvl,
    output logic signed [SW-1:0] scaled
);
    logic signed [SW+LW:0] prod;

    assign prod   = $signed(smp) * $signed({1'b0, lvl});
    assign scaled = SW'(prod >>> SHIFT);

endmodule

// File: rtl/fade_ctrl.sv
module fade_ctrl #(
    parameter int SAMPLE_W    = 16,
    parameter int FULL_LVL    = 128,
    parameter int FULL_OS_LVL = 120,
    parameter int ATTEN_LVL   = 32,
    parameter int TICK_DIV    = 1150
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [3:0]                 cmd_code,
    input  logic                       os_en,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_l,
    input  logic signed [SAMPLE_W-1:0] smp_r,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r,
    output logic                       muted
);
    localparam int LW    = $clog2(FULL_LVL + 1);
    localparam int SHIFT = $clog2(FULL_LVL);
    localparam int NCH   = 2;

    logic                       tick;
    logic [LW-1:0]              lvl;
    logic signed [SAMPLE_W-1:0] ch_in  [NCH];
    logic signed [SAMPLE_W-1:0] ch_out [NCH];

    fade_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fade_level #(
        .FULL_LVL    (FULL_LVL),
        .FULL_OS_LVL (FULL_OS_LVL),
        .ATTEN_LVL   (ATTEN_LVL),
        .LW          (LW)
    ) u_level (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .os_en     (os_en),
        .lvl       (lvl)
    );

    assign ch_in[0] = smp_l;
    assign ch_in[1] = smp_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        fade_scale #(.SW(SAMPLE_W), .LW(LW), .SHIFT(SHIFT)) u_scale (
            .smp    (ch_in[c]),
            .lvl    (lvl),
            .scaled (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) begin
                out_l <= ch_out[0];
                out_r <= ch_out[1];
            end
        end
    end

    assign muted = (lvl == '0);

    // R2: one clock from sample in to sample out
    p_out_valid_r2: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> out_valid);

    // R5: a sample taken while muted leaves as silence
    p_mute_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && muted) |=> (out_l == '0 && out_r == '0));

endmodule

// File: tb/sim_fade_ctrl.sv
module sim_fade_ctrl;
    localparam int DIV = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_code = 4'd0;
    logic              os_en = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [15:0] smp_l = '0;
    logic signed [15:0] smp_r = '0;
    logic              out_valid;
    logic signed [15:0] out_l;
    logic signed [15:0] out_r;
    logic              muted;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fade_ctrl #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .os_en(os_en), .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r), .muted(muted)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic send(input logic [3:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic probe(output int lv);
        smp_l = 16'sd16384;
        smp_r = 16'sd16384;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        lv = int'(out_l) / 128;
    endtask

    task automatic expect_lvl(input string req, input int exp);
        int lv;
        probe(lv);
        check(req, lv, exp);
    endtask

    task automatic apply(input int l, input int r, input int lev);
        smp_l = 16'(l);
        smp_r = 16'(r);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R2 valid", int'(out_valid), 1);
        check("R2 left", int'(out_l), (l * lev) >>> 7);
        check("R2 right", int'(out_r), (r * lev) >>> 7);
    endtask

    task automatic t_reset();
        check("R1 muted", int'(muted), 1);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_l", int'(out_l), 0);
        check("R1 out_r", int'(out_r), 0);
        expect_lvl("R1 level", 0);
    endtask

    task automatic t_ramp();
        send(4'b0001);
        idle(40);
        expect_lvl("R6 ten ticks", 10);
        check("R5 unmuted", int'(muted), 0);
        idle(128 * DIV - 41);
        expect_lvl("R6 R3 full ramp", 128);
    endtask

    task automatic t_scale();
        apply(1000, -1000, 128);
        apply(-32768, 32767, 128);
        idle(1);
        check("R2 valid drop", int'(out_valid), 0);
        send(4'b0010);
        idle(96 * DIV);
        expect_lvl("R4 attenuate", 32);
        apply(-101, 7, 32);
        apply(-32768, 12345, 32);
    endtask

    task automatic t_replace();
        send(4'b0001);
        idle(20);
        send(4'b0000);
        idle(12);
        expect_lvl("R9 reversal", 34);
        idle(40 * DIV);
        expect_lvl("R5 mute", 0);
        check("R5 muted flag", int'(muted), 1);
        apply(20000, -20000, 0);
    endtask

    task automatic t_ignore();
        send(4'b1001);
        idle(128 * DIV);
        expect_lvl("R10 bit3 ignored", 128);
        send(4'b0110);
        send(4'b1111);
        idle(20);
        expect_lvl("R10 unused codes", 128);
    endtask

    task automatic t_oversample();
        os_en = 1'b1;
        send(4'b0001);
        idle(8 * DIV);
        expect_lvl("R3 os ceiling", 120);
        send(4'b0101);
        expect_lvl("R8 up at ceiling", 120);
        send(4'b0100);
        expect_lvl("R7 step down", 119);
        idle(20);
        expect_lvl("R7 no ramp after step", 119);
        send(4'b0101);
        expect_lvl("R7 step up", 120);
    endtask

    task automatic t_floor();
        send(4'b0000);
        idle(120 * DIV);
        expect_lvl("R5 back to zero", 0);
        send(4'b0100);
        expect_lvl("R8 down at zero", 0);
        send(4'b0101);
        expect_lvl("R7 up from zero", 1);
        check("R5 flag clear", int'(muted), 0);
        os_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ramp();
        t_scale();
        t_replace();
        t_ignore();
        t_oversample();
        t_floor();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule